// File: doc/BRIEF.md
# Post-Transmit Collision-Presence Filter

This block sits on the collision-presence input of an attachment-unit-interface (AUI) port. After the port stops transmitting, the attached transceiver is allowed to send a short heartbeat burst on the collision pair. That burst is a self-test signal, not a real collision. The block counts bit-time ticks from the end of each transmission. While the count lies inside a fixed window, and only if the mask is enabled, it keeps that activity off the collision output.

A separate sticky flag records that heartbeat activity was seen in the window. The flag is set whether or not masking is on, so the heartbeat can still be reported while it is kept out of collision handling. Activity outside the window always counts as a genuine collision. Both outputs are registered and respond one clock after the inputs are sampled.

Top module: `sqe_ci_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `coll_out` and `sqe_seen` are 0 and no window is open.
- R2: The window starts counting at the clock edge that first samples `tx_active` low after it was high. The count then advances only on edges where `bit_tick` is 1.
- R3: The window is open while the tick count is at least `WIN_OPEN` (default 6) and below `WIN_CLOSE` (default 34). CI at count 5 or 34 lies outside the window. CI at count 6 or 33 lies inside it.
- R4: With `mask_en` at 1, CI sampled inside the window gives `coll_out` = 0 on the next cycle.
- R5: CI sampled outside the window reaches `coll_out` on the next cycle even when `mask_en` is 1.
- R6: With `mask_en` at 0, `coll_out` equals `ci_raw` delayed by one clock at all times.
- R7: CI sampled inside the window sets `sqe_seen` on the next cycle, whatever the value of `mask_en`.
- R8: `sqe_seen` stays set until a cycle with `sqe_clr` at 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: Sampling `tx_active` high closes any open window from the next cycle. CI during a transmission passes to `coll_out`.
- R10: CI outside the window never sets `sqe_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_active | input | 1 | High while the port transmits |
| ci_raw | input | 1 | Squelched collision-pair activity |
| mask_en | input | 1 | 1 = suppress in-window activity from `coll_out` |
| sqe_clr | input | 1 | Read-clear strobe for `sqe_seen` |
| coll_out | output | 1 | Filtered collision indication (registered) |
| sqe_seen | output | 1 | Sticky in-window heartbeat flag (registered) |

## Verification
The two functions that can meet in one cycle are the read-clear of the heartbeat flag and a fresh in-window CI sample that sets it again. Random stimulus produces clear strobes during window activity, and a directed case drives the clear together with an in-window CI sample. The flag must read 1 on the next cycle. A second collision occurs when a new transmission begins on the very edge where in-window CI arrives. The cycle-level model in the bench judges both cases.

// File: rtl/sqe_filt_pkg.sv
package sqe_filt_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_RUN = 1'b1} win_state_e;

  function automatic logic cnt_in_range(input int unsigned c, input int unsigned lo,
                                        input int unsigned hi);
    return (c >= lo) && (c < hi);
  endfunction
endpackage

// File: rtl/sqe_win_timer.sv
module sqe_win_timer
  import sqe_filt_pkg::*;
#(
  parameter int unsigned WIN_OPEN  = 6,
  parameter int unsigned WIN_CLOSE = 34,
  parameter int unsigned CNT_W     = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_active,
  output logic in_win
);
  logic             tx_q;
  win_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= 1'b0;
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else begin
      tx_q <= tx_active;
      if (tx_active) begin
        st_q  <= WIN_IDLE;
        cnt_q <= '0;
      end else if (tx_q) begin
        st_q  <= WIN_RUN;
        cnt_q <= '0;
      end else if (st_q == WIN_RUN && bit_tick) begin
        if (cnt_q == CNT_W'(WIN_CLOSE - 1)) st_q <= WIN_IDLE;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign in_win = (st_q == WIN_RUN) && cnt_in_range(32'(cnt_q), WIN_OPEN, WIN_CLOSE);

  // R9: a transmission closes the window
  p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !in_win);
  // R2: the window is never open straight after arming
  p_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && $past(tx_active)) |=> !in_win);
  // R2: without a tick the window state holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !tx_active && !tx_q) |=> $stable(in_win));
  // R3: the window opens only on a counted tick
  p_open_r3: assert property (@(posedge clk) disable iff (rst)
    (in_win && !$past(in_win)) |-> $past(bit_tick));
endmodule

// File: rtl/sqe_ci_gate.sv
module sqe_ci_gate (
  input  logic clk,
  input  logic rst,
  input  logic ci_raw,
  input  logic mask_en,
  input  logic in_win,
  output logic coll_out
);
  always_ff @(posedge clk) begin
    if (rst) coll_out <= 1'b0;
    else     coll_out <= ci_raw & ~(mask_en & in_win);
  end

  p_nomask_pass_r6: assert property (@(posedge clk) disable iff (rst)
    !mask_en |=> (coll_out == $past(ci_raw)));
  p_mask_block_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_en && in_win) |=> !coll_out);
  p_outside_pass_r5: assert property (@(posedge clk) disable iff (rst)
    !in_win |=> (coll_out == $past(ci_raw)));
endmodule

// File: rtl/sqe_report.sv
module sqe_report (
  input  logic clk,
  input  logic rst,
  input  logic ci_raw,
  input  logic in_win,
  input  logic sqe_clr,
  output logic sqe_seen
);
  logic hit;
  assign hit = ci_raw & in_win;

  always_ff @(posedge clk) begin
    if (rst) sqe_seen <= 1'b0;
    else     sqe_seen <= (sqe_seen & ~sqe_clr) | hit;
  end

  p_set_r7: assert property (@(posedge clk) disable iff (rst)
    (ci_raw && in_win) |=> sqe_seen);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (sqe_seen && !sqe_clr) |=> sqe_seen);
  p_noset_r10: assert property (@(posedge clk) disable iff (rst)
    (!sqe_seen && !(ci_raw && in_win)) |=> !sqe_seen);
endmodule

// File: rtl/sqe_ci_filter.sv
module sqe_ci_filter #(
  parameter int unsigned WIN_OPEN  = 6,
  parameter int unsigned WIN_CLOSE = 34
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_active,
  input  logic ci_raw,
  input  logic mask_en,
  input  logic sqe_clr,
  output logic coll_out,
  output logic sqe_seen
);
  localparam int unsigned CNT_W = $clog2(WIN_CLOSE + 1);

  logic in_win;

  sqe_win_timer #(
    .WIN_OPEN (WIN_OPEN),
    .WIN_CLOSE(WIN_CLOSE),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .tx_active(tx_active),
    .in_win   (in_win)
  );

  sqe_ci_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .ci_raw  (ci_raw),
    .mask_en (mask_en),
    .in_win  (in_win),
    .coll_out(coll_out)
  );

  sqe_report u_report (
    .clk     (clk),
    .rst     (rst),
    .ci_raw  (ci_raw),
    .in_win  (in_win),
    .sqe_clr (sqe_clr),
    .sqe_seen(sqe_seen)
  );

  // R1: outputs idle in the cycle after reset
  p_reset_r1: assert property (@(posedge clk) rst |=> (!coll_out && !sqe_seen));
endmodule

// File: tb/tb_sqe_ci_filter.sv
module tb_sqe_ci_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, tx_active = 1'b0, ci_raw = 1'b0, mask_en = 1'b0, sqe_clr = 1'b0;
  logic coll_out, sqe_seen;

  int checks = 0;
  int errors = 0;

  int m_cnt = 0;
  bit m_arm = 0, m_txd = 0, m_seen = 0;
  bit exp_coll = 0, exp_seen = 0, last_inwin = 0;

  always #10 clk = ~clk;

  sqe_ci_filter dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_active(tx_active),
    .ci_raw(ci_raw), .mask_en(mask_en), .sqe_clr(sqe_clr),
    .coll_out(coll_out), .sqe_seen(sqe_seen)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit win_open(input bit arm, input int cnt);
    return arm && cnt >= 6 && cnt < 34;
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit tx, input bit ci, input bit tk, input bit mk, input bit cl);
    bit prev_seen;
    tx_active = tx; ci_raw = ci; bit_tick = tk; mask_en = mk; sqe_clr = cl;
    @(posedge clk);
    last_inwin = win_open(m_arm, m_cnt);
    prev_seen  = m_seen;
    exp_coll   = ci && !(mk && last_inwin);
    exp_seen   = (m_seen && !cl) || (ci && last_inwin);
    m_seen     = exp_seen;
    if (tx) begin
      m_arm = 0; m_cnt = 0;
    end else if (m_txd) begin
      m_arm = 1; m_cnt = 0;
    end else if (m_arm && tk) begin
      m_cnt++;
      if (m_cnt == 34) m_arm = 0;
    end
    m_txd = tx;
    @(negedge clk);
    if (tx && ci)          chk("R9 coll_out during tx", coll_out, exp_coll);
    else if (!mk)          chk("R6 coll_out unmasked", coll_out, exp_coll);
    else if (last_inwin)   chk("R4 coll_out masked in window", coll_out, exp_coll);
    else                   chk("R5 coll_out outside window", coll_out, exp_coll);
    if (ci && last_inwin)  chk("R7 sqe_seen set", sqe_seen, exp_seen);
    else if (prev_seen)    chk("R8 sqe_seen sticky/clear", sqe_seen, exp_seen);
    else                   chk("R10 sqe_seen no set", sqe_seen, exp_seen);
  endtask

  task automatic arm_window(input bit mk);
    step(1, 0, 0, mk, 0);
    step(1, 0, 0, mk, 0);
    step(0, 0, 0, mk, 0);
  endtask

  // CI one cycle after n counted ticks; checks the window edge (R3)
  task automatic probe(input int n, input bit mk);
    arm_window(mk);
    for (int i = 0; i < n; i++) step(0, 0, 1, mk, 0);
    step(0, 1, 0, mk, 0);
    chk($sformatf("R3 edge n=%0d mask=%0d", n, mk), coll_out, !(mk && n >= 6 && n < 34));
    step(0, 0, 0, mk, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit txs, mk;
    void'($urandom(32'h5EC0_1D42));
    // R1: reset holds outputs low despite activity
    rst = 1'b1; ci_raw = 1'b1; tx_active = 1'b1; mask_en = 1'b0;
    repeat (3) @(posedge clk);
    tx_active = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 coll_out in reset", coll_out, 1'b0);
    chk("R1 sqe_seen in reset", sqe_seen, 1'b0);
    rst = 1'b0; ci_raw = 1'b0;
    @(negedge clk);
    chk("R1 coll_out after reset", coll_out, 1'b0);
    chk("R1 sqe_seen after reset", sqe_seen, 1'b0);

    // R3 boundaries, masked and unmasked
    probe(5, 1); probe(6, 1); probe(33, 1); probe(34, 1);
    probe(10, 0); probe(20, 1);

    // R2: count advances only on ticks
    arm_window(1);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0);
    step(0, 1, 0, 1, 0);
    chk("R2 no advance without tick", coll_out, 1'b1);
    step(0, 0, 1, 1, 0);
    step(0, 1, 0, 1, 0);
    chk("R2 advance on tick", coll_out, 1'b0);

    // R9: new transmission cancels the window
    step(1, 1, 1, 1, 0);
    step(1, 1, 0, 1, 0);
    chk("R9 cancelled window passes CI", coll_out, 1'b1);

    // R8: clear and set in one cycle, set wins; then clear alone
    arm_window(1);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1, 0);
    step(0, 1, 0, 1, 0);
    step(0, 1, 0, 1, 1);
    chk("R8 set wins over clear", sqe_seen, 1'b1);
    step(0, 0, 0, 1, 1);
    chk("R8 clear alone", sqe_seen, 1'b0);

    // random mix
    txs = 0; mk = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 30 == 0) txs = !txs;
      if ($urandom % 200 == 0) mk = !mk;
      step(txs, ($urandom % 6) == 0, ($urandom % 2) == 0, mk, ($urandom % 15) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule